// File: doc/BRIEF.md
# Masked Time-of-Day Alarm with Shared Test-Frequency Interrupt

This block watches the current BCD second, minute, hour and date from a clock core and compares them with four alarm registers. The top bit of each alarm register is a mask bit. Together the four mask bits choose how often the alarm repeats: every second, every minute, every hour, every day, or once a month on a set date. A mask pattern outside that set is treated as every second, so a bad setting shows up at once instead of never firing.

A match on a one-second tick sets a sticky alarm flag. While the alarm path is armed, the flag pulls an active-low open-drain interrupt pin low. On main power the pin is armed by the alarm-enable bit. On battery it is armed by the backup-enable bit, so a timed wake-up still works. Reading the flags register clears the flag.

The same pin also carries a test square wave for measuring the oscillator. The wave is produced only when the oscillator runs, the test bit is set and the alarm is disabled, and only while the watchdog is either steered away from the pin or idle. The pin is modelled as an output enable that can only pull low. The watchdog counter itself lives elsewhere.

Top module: `alarmIrqUnit`

## Requirements
- R1: After reset the alarm flag is 0 and the pin is released (irqPullLow = 0).
- R2: Bit 7 of almSec, almMin, almHour and almDate is the mask bit AM1, AM2, AM3 and AM4 respectively. A mask bit of 1 drops that field from the comparison, and bits [6:0] of each field are compared with the matching current-time input. Pattern {AM4,AM3,AM2,AM1} = 1111 matches every second.
- R3: Pattern 1110 matches on seconds alone. Pattern 1100 matches on seconds and minutes. Pattern 1000 matches on seconds, minutes and hours.
- R4: Pattern 0000 matches only when date, hour, minute and second all match.
- R5: Any pattern other than 1111, 1110, 1100, 1000 and 0000 matches every second, whatever the field values.
- R6: The match is sampled only on a cycle where secTick and oscRun are both 1. The flag rises on the clock edge that samples such a tick and at no other time.
- R7: The alarm is armed by alarmEn when onBattery = 0 and by backupAlarmEn when onBattery = 1. The flag is set only if the alarm is armed at the tick. The pin is pulled low while the flag is 1 and the alarm is armed.
- R8: The flag stays at 1 until a cycle with flagRead = 1 clears it at the next edge. If a set and a read fall in the same cycle, the set wins.
- R9: Test mode is active while oscRun = 1, freqTestEn = 1, alarmEn = 0, and either wdSteer = 1 or wdZero = 1. In test mode each tglTick pulse (at 1024 Hz, which gives a 512 Hz wave) toggles the pin, starting from released. Outside test mode the wave phase is cleared and the wave does not pull the pin.
- R10: The pin is pulled low if either the armed alarm flag or the test wave asks for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle pulse each second |
| tglTick | input | 1 | One-cycle pulse at 1024 Hz for the test wave |
| oscRun | input | 1 | Oscillator running |
| onBattery | input | 1 | Running from backup supply |
| curSec | input | 8 | Current BCD seconds |
| curMin | input | 8 | Current BCD minutes |
| curHour | input | 8 | Current BCD hours |
| curDate | input | 8 | Current BCD day of month |
| almSec | input | 8 | Alarm seconds, bit 7 = AM1 |
| almMin | input | 8 | Alarm minutes, bit 7 = AM2 |
| almHour | input | 8 | Alarm hours, bit 7 = AM3 |
| almDate | input | 8 | Alarm date, bit 7 = AM4 |
| alarmEn | input | 1 | Alarm enable on main power |
| backupAlarmEn | input | 1 | Alarm enable on battery |
| freqTestEn | input | 1 | Test-frequency mode request |
| wdSteer | input | 1 | Watchdog steered away from this pin |
| wdZero | input | 1 | Watchdog register is zero |
| flagRead | input | 1 | Flags register read strobe |
| irqPullLow | output | 1 | Pin output enable (1 = drive low) |
| alarmFlag | output | 1 | Sticky alarm flag |

## Verification
The bench aims at the mask decode at the edges of each repeat mode. For each mode it shows a one-field mismatch that must not fire and a full match that must, so a decoder that compared a masked field, or skipped an unmasked one, misses or fires falsely. An undefined pattern with every field wrong must still fire, and a design that treated it as "compare everything" would stay silent. A read that lands in the same cycle as a new match must leave the flag set, where a design giving the read priority would lose an alarm. The battery path, a stopped oscillator, and test-mode gating by the alarm-enable bit and by the watchdog terms are each checked at the pin.

// File: rtl/alarmIrqPkg.sv
package alarmIrqPkg;
  localparam int NUM_FIELDS = 4;  // 0 sec, 1 min, 2 hour, 3 date

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic toggle;
    logic clearPhase;
  } dpStrobes_t;
endpackage

// File: rtl/alarmCtrl.sv
module alarmCtrl
  import alarmIrqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       tglTick,
  input  logic       oscRun,
  input  logic       onBattery,
  input  logic       alarmEn,
  input  logic       backupAlarmEn,
  input  logic       freqTestEn,
  input  logic       wdSteer,
  input  logic       wdZero,
  input  logic       flagRead,
  input  logic       match,
  output dpStrobes_t str,
  output logic       armed,
  output logic       ftActive
);
  logic tickValid;

  always_comb begin
    armed     = onBattery ? backupAlarmEn : alarmEn;
    ftActive  = oscRun & freqTestEn & ~alarmEn & (wdSteer | wdZero);
    tickValid = secTick & oscRun;
    str.setFlag    = tickValid & match & armed;
    str.clrFlag    = flagRead & ~str.setFlag;
    str.toggle     = ftActive & tglTick;
    str.clearPhase = ~ftActive;
  end

  // R9: the wave never advances unless the oscillator runs and the alarm is off
  p_toggle_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.toggle |-> (oscRun && freqTestEn && !alarmEn));

  // R6: no flag set without a live second tick
  p_set_needs_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    str.setFlag |-> (secTick && oscRun));
endmodule

// File: rtl/alarmDatapath.sv
module alarmDatapath
  import alarmIrqPkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   curVec,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]   almVec,
  input  dpStrobes_t                           str,
  output logic                                 match,
  output logic                                 alarmFlag,
  output logic                                 phase
);
  localparam int VAL_W = FIELD_W - 1;

  logic [NUM_FIELDS-1:0] fieldEq;
  logic [NUM_FIELDS-1:0] maskBits;
  logic [NUM_FIELDS-1:0] maskUp;
  logic [NUM_FIELDS-1:0] effMask;
  logic                  patternOk;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fieldEq[i]  = (curVec[i][VAL_W-1:0] == almVec[i][VAL_W-1:0]);
    assign maskBits[i] = almVec[i][FIELD_W-1];
  end

  // Defined patterns are a thermometer: a set mask bit implies the next one up is set
  always_comb begin
    maskUp    = maskBits << 1;
    patternOk = ((maskUp & ~maskBits) == '0);
    effMask   = patternOk ? maskBits : '1;
    match     = &(fieldEq | effMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      phase     <= 1'b0;
    end else begin
      if (str.setFlag)      alarmFlag <= 1'b1;
      else if (str.clrFlag) alarmFlag <= 1'b0;
      if (str.clearPhase)   phase <= 1'b0;
      else if (str.toggle)  phase <= ~phase;
    end
  end

  // R8: flag holds unless a read strobe reaches it
  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !str.clrFlag) |=> alarmFlag);

  // R9: each toggle strobe flips the wave
  p_phase_flips_r9: assert property (@(posedge clk) disable iff (!rstN)
    (str.toggle && !str.clearPhase) |=> (phase != $past(phase)));
endmodule

// File: rtl/alarmIrqUnit.sv
module alarmIrqUnit
  import alarmIrqPkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               secTick,
  input  logic               tglTick,
  input  logic               oscRun,
  input  logic               onBattery,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] almSec,
  input  logic [FIELD_W-1:0] almMin,
  input  logic [FIELD_W-1:0] almHour,
  input  logic [FIELD_W-1:0] almDate,
  input  logic               alarmEn,
  input  logic               backupAlarmEn,
  input  logic               freqTestEn,
  input  logic               wdSteer,
  input  logic               wdZero,
  input  logic               flagRead,
  output logic               irqPullLow,
  output logic               alarmFlag
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] curVec;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] almVec;
  dpStrobes_t str;
  logic match, armed, ftActive, phase;

  assign curVec = {curDate, curHour, curMin, curSec};
  assign almVec = {almDate, almHour, almMin, almSec};

  alarmCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .tglTick(tglTick),
    .oscRun(oscRun), .onBattery(onBattery), .alarmEn(alarmEn),
    .backupAlarmEn(backupAlarmEn), .freqTestEn(freqTestEn),
    .wdSteer(wdSteer), .wdZero(wdZero), .flagRead(flagRead),
    .match(match), .str(str), .armed(armed), .ftActive(ftActive)
  );

  alarmDatapath #(.FIELD_W(FIELD_W)) i_dp (
    .clk(clk), .rstN(rstN), .curVec(curVec), .almVec(almVec),
    .str(str), .match(match), .alarmFlag(alarmFlag), .phase(phase)
  );

  assign irqPullLow = (alarmFlag & armed) | (ftActive & phase);

  // R6: flag only rises on the edge after a live tick
  p_rise_after_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(secTick && oscRun));

  // R8: a read without a tick clears the flag
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !secTick) |=> !alarmFlag);

  // R10: with the main-power alarm enabled the pin follows the flag only
  p_pin_alarm_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (alarmEn && !onBattery) |-> (irqPullLow == alarmFlag));
endmodule

// File: tb/test_alarmIrqUnit.sv
module test_alarmIrqUnit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 0, tglTick = 0, oscRun = 1, onBattery = 0;
  logic [7:0] curSec = 8'h30, curMin = 8'h15, curHour = 8'h09, curDate = 8'h21;
  logic [7:0] almSec = 0, almMin = 0, almHour = 0, almDate = 0;
  logic alarmEn = 0, backupAlarmEn = 0, freqTestEn = 0, wdSteer = 0, wdZero = 0;
  logic flagRead = 0;
  logic irqPullLow, alarmFlag;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarmIrqUnit i_alarmIrqUnit (
    .clk(clk), .rstN(rstN), .secTick(secTick), .tglTick(tglTick),
    .oscRun(oscRun), .onBattery(onBattery),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDate(curDate),
    .almSec(almSec), .almMin(almMin), .almHour(almHour), .almDate(almDate),
    .alarmEn(alarmEn), .backupAlarmEn(backupAlarmEn), .freqTestEn(freqTestEn),
    .wdSteer(wdSteer), .wdZero(wdZero), .flagRead(flagRead),
    .irqPullLow(irqPullLow), .alarmFlag(alarmFlag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // pulse the second tick for one cycle; on return the edge that sampled it has passed
  task automatic doTick();
    @(negedge clk) secTick = 1;
    @(negedge clk) secTick = 0;
  endtask

  task automatic doRead();
    @(negedge clk) flagRead = 1;
    @(negedge clk) flagRead = 0;
  endtask

  task automatic doTgl();
    @(negedge clk) tglTick = 1;
    @(negedge clk) tglTick = 0;
  endtask

  // set masks {AM4,AM3,AM2,AM1} and values
  task automatic setAlarm(input logic [3:0] m, input logic [6:0] s, input logic [6:0] mi,
                          input logic [6:0] h, input logic [6:0] d);
    @(negedge clk);
    almSec  = {m[0], s};
    almMin  = {m[1], mi};
    almHour = {m[2], h};
    almDate = {m[3], d};
  endtask

  task automatic expectTick(input string req, input logic exp);
    doTick();
    chk(req, alarmFlag, exp);
    doRead();
  endtask

  task automatic testReset();
    chk("R1 flag", alarmFlag, 1'b0);
    chk("R1 pin", irqPullLow, 1'b0);
  endtask

  task automatic testEverySecond();
    alarmEn = 1;
    setAlarm(4'b1111, 7'h00, 7'h00, 7'h00, 7'h00);
    repeat (3) @(negedge clk);
    chk("R6 no tick no flag", alarmFlag, 1'b0);
    doTick();
    chk("R2 every second flag", alarmFlag, 1'b1);
    chk("R7 pin pulled", irqPullLow, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 flag holds", alarmFlag, 1'b1);
    doRead();
    chk("R8 read clears flag", alarmFlag, 1'b0);
    chk("R8 read releases pin", irqPullLow, 1'b0);
  endtask

  task automatic testModes();
    setAlarm(4'b1110, 7'h30, 7'h00, 7'h00, 7'h00);
    expectTick("R3 sec match", 1'b1);
    setAlarm(4'b1110, 7'h31, 7'h15, 7'h09, 7'h21);
    expectTick("R3 sec mismatch", 1'b0);
    setAlarm(4'b1100, 7'h30, 7'h16, 7'h00, 7'h00);
    expectTick("R3 min mismatch", 1'b0);
    setAlarm(4'b1100, 7'h30, 7'h15, 7'h00, 7'h00);
    expectTick("R3 min+sec match", 1'b1);
    setAlarm(4'b1000, 7'h30, 7'h15, 7'h08, 7'h00);
    expectTick("R3 hour mismatch", 1'b0);
    setAlarm(4'b1000, 7'h30, 7'h15, 7'h09, 7'h00);
    expectTick("R3 hour match", 1'b1);
    setAlarm(4'b0000, 7'h30, 7'h15, 7'h09, 7'h22);
    expectTick("R4 date mismatch", 1'b0);
    setAlarm(4'b0000, 7'h30, 7'h15, 7'h09, 7'h21);
    expectTick("R4 full match", 1'b1);
    setAlarm(4'b0101, 7'h00, 7'h00, 7'h00, 7'h00);
    expectTick("R5 undefined 0101", 1'b1);
    setAlarm(4'b0001, 7'h00, 7'h00, 7'h00, 7'h00);
    expectTick("R5 undefined 0001", 1'b1);
  endtask

  task automatic testArming();
    setAlarm(4'b1111, 7'h00, 7'h00, 7'h00, 7'h00);
    @(negedge clk) alarmEn = 0;
    expectTick("R7 disarmed no flag", 1'b0);
    @(negedge clk) begin onBattery = 1; backupAlarmEn = 1; end
    doTick();
    chk("R7 backup flag", alarmFlag, 1'b1);
    chk("R7 backup pin", irqPullLow, 1'b1);
    @(negedge clk) backupAlarmEn = 0;
    @(negedge clk);
    chk("R7 disarm releases pin", irqPullLow, 1'b0);
    chk("R7 flag kept", alarmFlag, 1'b1);
    doRead();
    @(negedge clk) begin onBattery = 0; alarmEn = 1; end
    doTick();
    @(negedge clk) begin secTick = 1; flagRead = 1; end
    @(negedge clk) begin secTick = 0; flagRead = 0; end
    chk("R8 set beats read", alarmFlag, 1'b1);
    doRead();
    @(negedge clk) oscRun = 0;
    expectTick("R6 osc stopped", 1'b0);
    @(negedge clk) oscRun = 1;
  endtask

  task automatic testFreq();
    @(negedge clk) begin alarmEn = 0; freqTestEn = 1; wdSteer = 1; end
    @(negedge clk);
    chk("R9 starts released", irqPullLow, 1'b0);
    doTgl();
    chk("R9 first toggle", irqPullLow, 1'b1);
    doTgl();
    chk("R9 second toggle", irqPullLow, 1'b0);
    @(negedge clk) wdSteer = 0;
    doTgl();
    chk("R9 watchdog blocks", irqPullLow, 1'b0);
    @(negedge clk) wdZero = 1;
    doTgl();
    chk("R9 watchdog zero enables", irqPullLow, 1'b1);
    @(negedge clk) alarmEn = 1;
    @(negedge clk);
    chk("R9 alarmEn blocks wave", irqPullLow, 1'b0);
    doTgl();
    chk("R9 alarmEn blocks toggle", irqPullLow, 1'b0);
    @(negedge clk) begin alarmEn = 0; onBattery = 1; backupAlarmEn = 1; end
    @(negedge clk);
    chk("R9 phase cleared", irqPullLow, 1'b0);
    doTick();
    chk("R10 alarm pulls during wave low-phase", irqPullLow, 1'b1);
    doTgl();
    chk("R10 both sources pull", irqPullLow, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    @(negedge clk) rstN = 1;
    testEverySecond();
    testModes();
    testArming();
    testFreq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule